// File: doc/BRIEF.md
# Delayed-Completion Discard Timer Bank

This block watches the delayed-completion queues of a PCI-to-PCI bridge and frees any queue whose originating master never comes back for its data. It holds eight watchdog timers, one per completion queue. There is one read queue and one write queue for each direction, on each bus interface. Queues 0 to 3 hold cycles that originate on the primary interface. Queues 4 to 7 hold cycles that originate on the secondary interface. A timer starts when its queue's request has finished on the destination bus and a completion is waiting. It stops when the master retries and takes the completion, or when the queue is flushed for another reason.

The timeout is 2^10 or 2^15 clocks. A separate configuration bit selects it for each originating interface. When a timer runs out, the block sends a one-clock invalidate pulse to the owning queue and sets a sticky status flag, whatever the enables are. It also pulses the system-error output, but only if both the global error enable and the discard error enable are set. A global disable freezes every timer at its current count, so completions stay queued until they are taken.

Each timer is a three-state machine:
- IDLE: no completion is waiting. Arm moves to RUN.
- RUN: counting. A take or a flush moves back to IDLE. Reaching the limit while counting is allowed moves to FIRE. Otherwise the timer counts, or holds while disabled.
- FIRE: the invalidate pulse. The next clock always moves to IDLE.

Top module: `pci_discard_timer_bank`

## Requirements
- R1: Each of the eight timers is independent. An arm pulse on `cpl_ready_i[i]` starts timer i only when it is idle. An arm pulse that comes while the timer is counting is ignored and does not restart the count.
- R2: For queues 0 to 3, `cfg_pri_short_i`=1 selects a 1024-clock timeout and 0 selects a 32768-clock timeout. The invalidate pulse is high in the cycle after the clock edge that lies exactly that many clocks after the arming edge.
- R3: For queues 4 to 7, `cfg_sec_short_i` selects the timeout with the same encoding and the same timing as R2.
- R4: A pulse on `cpl_taken_i[i]` or `q_flush_i[i]` returns timer i to idle with no invalidate and no status change. This holds even in the cycle where the timer would otherwise expire.
- R5: An expiry drives a single one-clock pulse on bit i of `q_inval_o`. Timers that expire on the same edge all pulse their own bits in the same cycle.
- R6: `dt_status_o` is set in the same cycle as any invalidate pulse, regardless of the enables. It stays set until `sts_clr_i` is high at a clock edge. When an expiry and a clear happen on the same edge, the set wins.
- R7: `serr_o` is a single one-clock pulse for each expiry cycle, coincident with the invalidate pulse. It is raised only if `cfg_serr_en_i` and `cfg_dt_serr_en_i` are both 1 at the expiring edge.
- R8: While `cfg_dt_disable_i` is 1, no timer advances and none expires. When it returns to 0, counting resumes from the held value, so the expiry comes after the selected number of enabled clocks in total.
- R9: After reset all timers are idle and `q_inval_o`, `dt_status_o` and `serr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_ready_i | input | 8 | Per-queue pulse: delayed completion formed, arm timer |
| cpl_taken_i | input | 8 | Per-queue pulse: originating master took the completion |
| q_flush_i | input | 8 | Per-queue pulse: queue invalidated by other logic |
| cfg_pri_short_i | input | 1 | 1 selects 2^10, 0 selects 2^15 for queues 0..3 |
| cfg_sec_short_i | input | 1 | 1 selects 2^10, 0 selects 2^15 for queues 4..7 |
| cfg_dt_disable_i | input | 1 | 1 freezes all timers |
| cfg_serr_en_i | input | 1 | Global system-error enable |
| cfg_dt_serr_en_i | input | 1 | Discard-timer system-error enable |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| q_inval_o | output | 8 | Per-queue one-clock invalidate pulse |
| dt_status_o | output | 1 | Sticky discard-timer status flag |
| serr_o | output | 1 | One-clock system-error pulse |

## Verification
The hardest case to reach from the ports is a status clear that lands on the same edge as an expiry. The bench reaches it by computing the exact expiry cycle from the arming edge and raising the clear strobe one cycle earlier, so that it is high at the firing edge. The frozen-timer case is also hard: an arm is issued while the timers are disabled, the disable is held for thousands of clocks, and then it is released. The bench checks that the pulse arrives 1024 clocks after the release and not at any earlier time. A scoreboard of expected pulse cycles catches any invalidate or error pulse that arrives early, late, or without an expectation.

// File: rtl/pcidt_pkg.sv
package pcidt_pkg;
    typedef enum logic [1:0] {
        DT_IDLE = 2'd0,
        DT_RUN  = 2'd1,
        DT_FIRE = 2'd2
    } dt_state_e;
endpackage

// File: rtl/dt_timer.sv
module dt_timer
    import pcidt_pkg::*;
#(
    parameter int SHORT_LOG = 10,
    parameter int LONG_LOG  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic retire_i,
    input  logic freeze_i,
    input  logic short_i,
    output logic hit_o,
    output logic fire_o
);
    localparam int CW = LONG_LOG;
    localparam logic [CW-1:0] SHORT_MAX = CW'((1 << SHORT_LOG) - 1);
    localparam logic [CW-1:0] LONG_MAX  = CW'((1 << LONG_LOG) - 1);

    dt_state_e      state, nxt;
    logic [CW-1:0]  count, cnt_nxt;
    logic [CW-1:0]  lim_m1;
    logic           hit;

    assign lim_m1 = short_i ? SHORT_MAX : LONG_MAX;
    assign hit    = (state == DT_RUN) && !retire_i && !freeze_i && (count >= lim_m1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DT_IDLE;
            count <= '0;
        end else begin
            state <= nxt;
            count <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = count;
        unique case (state)
            DT_IDLE: begin
                if (arm_i) begin
                    nxt     = DT_RUN;
                    cnt_nxt = '0;
                end
            end
            DT_RUN: begin
                if (retire_i) begin
                    nxt     = DT_IDLE;
                    cnt_nxt = '0;
                end else if (hit) begin
                    nxt     = DT_FIRE;
                    cnt_nxt = '0;
                end else if (!freeze_i) begin
                    cnt_nxt = count + 1'b1;
                end
            end
            DT_FIRE: nxt = DT_IDLE;
            default: nxt = DT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hit_o  = hit;
        fire_o = (state == DT_FIRE);
    end
endmodule

// File: rtl/dt_report.sv
module dt_report #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] hit_vec_i,
    input  logic          sts_clr_i,
    input  logic          serr_en_i,
    input  logic          dt_serr_en_i,
    output logic          status_o,
    output logic          serr_o
);
    logic any_hit;
    assign any_hit = |hit_vec_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= 1'b0;
            serr_o   <= 1'b0;
        end else begin
            status_o <= (status_o & ~sts_clr_i) | any_hit;
            serr_o   <= any_hit & serr_en_i & dt_serr_en_i;
        end
    end
endmodule

// File: rtl/pci_discard_timer_bank.sv
module pci_discard_timer_bank #(
    parameter int NQ        = 8,
    parameter int SHORT_LOG = 10,
    parameter int LONG_LOG  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] cpl_ready_i,
    input  logic [NQ-1:0] cpl_taken_i,
    input  logic [NQ-1:0] q_flush_i,
    input  logic          cfg_pri_short_i,
    input  logic          cfg_sec_short_i,
    input  logic          cfg_dt_disable_i,
    input  logic          cfg_serr_en_i,
    input  logic          cfg_dt_serr_en_i,
    input  logic          sts_clr_i,
    output logic [NQ-1:0] q_inval_o,
    output logic          dt_status_o,
    output logic          serr_o
);
    localparam int HALF = NQ / 2;

    logic [NQ-1:0] hit_vec;

    for (genvar gi = 0; gi < NQ; gi++) begin : g_tmr
        logic sel_short;
        if (gi < HALF) begin : g_pri
            assign sel_short = cfg_pri_short_i;
        end else begin : g_sec
            assign sel_short = cfg_sec_short_i;
        end
        dt_timer #(
            .SHORT_LOG (SHORT_LOG),
            .LONG_LOG  (LONG_LOG)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (cpl_ready_i[gi]),
            .retire_i (cpl_taken_i[gi] | q_flush_i[gi]),
            .freeze_i (cfg_dt_disable_i),
            .short_i  (sel_short),
            .hit_o    (hit_vec[gi]),
            .fire_o   (q_inval_o[gi])
        );
    end

    dt_report #(.NQ(NQ)) u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_vec_i    (hit_vec),
        .sts_clr_i    (sts_clr_i),
        .serr_en_i    (cfg_serr_en_i),
        .dt_serr_en_i (cfg_dt_serr_en_i),
        .status_o     (dt_status_o),
        .serr_o       (serr_o)
    );
endmodule

// File: rtl/dt_bank_chk.sv
module dt_bank_chk #(
    parameter int NQ = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NQ-1:0] cpl_taken_i,
    input logic [NQ-1:0] q_flush_i,
    input logic          cfg_dt_disable_i,
    input logic          cfg_serr_en_i,
    input logic          cfg_dt_serr_en_i,
    input logic          sts_clr_i,
    input logic [NQ-1:0] q_inval_o,
    input logic          dt_status_o,
    input logic          serr_o
);
    // R6
    status_with_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_inval_o != '0) |-> dt_status_o);

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_status_o && !sts_clr_i) |=> dt_status_o);

    // R7
    serr_needs_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> (q_inval_o != '0));

    // R7
    serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(cfg_serr_en_i && cfg_dt_serr_en_i));

    // R5
    inval_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_inval_o != '0) |=> ((q_inval_o & $past(q_inval_o)) == '0));

    // R8
    frozen_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dt_disable_i |=> (q_inval_o == '0));

    // R4
    retire_blocks_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpl_taken_i | q_flush_i) != '0) |=>
            ((q_inval_o & $past(cpl_taken_i | q_flush_i)) == '0));
endmodule

bind pci_discard_timer_bank dt_bank_chk #(.NQ(NQ)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cpl_taken_i      (cpl_taken_i),
    .q_flush_i        (q_flush_i),
    .cfg_dt_disable_i (cfg_dt_disable_i),
    .cfg_serr_en_i    (cfg_serr_en_i),
    .cfg_dt_serr_en_i (cfg_dt_serr_en_i),
    .sts_clr_i        (sts_clr_i),
    .q_inval_o        (q_inval_o),
    .dt_status_o      (dt_status_o),
    .serr_o           (serr_o)
);

// File: tb/pci_discard_timer_bank_tb.sv
`timescale 1ns/1ps
module pci_discard_timer_bank_tb;
    localparam int SHORT_T = 1024;
    localparam int LONG_T  = 32768;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpl_ready_i = '0, cpl_taken_i = '0, q_flush_i = '0;
    logic       cfg_pri_short_i = 1'b1, cfg_sec_short_i = 1'b1, cfg_dt_disable_i = 1'b0;
    logic       cfg_serr_en_i = 1'b1, cfg_dt_serr_en_i = 1'b1, sts_clr_i = 1'b0;
    logic [7:0] q_inval_o;
    logic       dt_status_o, serr_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int         at;
        logic [7:0] mask;
        logic       serr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pci_discard_timer_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpl_ready_i(cpl_ready_i), .cpl_taken_i(cpl_taken_i), .q_flush_i(q_flush_i),
        .cfg_pri_short_i(cfg_pri_short_i), .cfg_sec_short_i(cfg_sec_short_i),
        .cfg_dt_disable_i(cfg_dt_disable_i), .cfg_serr_en_i(cfg_serr_en_i),
        .cfg_dt_serr_en_i(cfg_dt_serr_en_i), .sts_clr_i(sts_clr_i),
        .q_inval_o(q_inval_o), .dt_status_o(dt_status_o), .serr_o(serr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares invalidate/serr pulses against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].at == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " inval"}, {24'd0, q_inval_o}, {24'd0, e.mask});
                check({e.tag, " serr"}, {31'd0, serr_o}, {31'd0, e.serr});
            end else if (q_inval_o != '0 || serr_o) begin
                check("R5 unexpected pulse", {23'd0, serr_o, q_inval_o}, 32'd0);
            end
        end
    end

    task automatic arm(input logic [7:0] m, output int at);
        cpl_ready_i = m;
        at = cyc + 1;
        @(negedge clk);
        cpl_ready_i = '0;
    endtask

    task automatic push(input int at, input logic [7:0] m, input logic s, input string tag);
        exp_t e;
        e.at = at; e.mask = m; e.serr = s; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_status();
        sts_clr_i = 1'b1;
        @(negedge clk);
        sts_clr_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a;
        repeat (5) @(negedge clk);
        // R9 reset state
        check("R9 inval", {24'd0, q_inval_o}, 32'd0);
        check("R9 status", {31'd0, dt_status_o}, 32'd0);
        check("R9 serr", {31'd0, serr_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 primary short timeout; R1 re-arm while counting ignored
        arm(8'h01, a);
        push(a + SHORT_T, 8'h01, 1'b1, "R2");
        repeat (300) @(negedge clk);
        begin int b; arm(8'h01, b); end
        drain();
        check("R6 status set", {31'd0, dt_status_o}, 32'd1);
        clear_status();
        check("R6 status cleared", {31'd0, dt_status_o}, 32'd0);

        // R4 take and flush stop timers
        arm(8'h02, a);
        repeat (500) @(negedge clk);
        cpl_taken_i = 8'h02; @(negedge clk); cpl_taken_i = '0;
        arm(8'h10, a);
        repeat (600) @(negedge clk);
        q_flush_i = 8'h10; @(negedge clk); q_flush_i = '0;
        repeat (1200) @(negedge clk);
        check("R4 no status after retire", {31'd0, dt_status_o}, 32'd0);

        // R3 secondary long timeout; R7 serr gated off, R6 status unconditional
        cfg_sec_short_i  = 1'b0;
        cfg_dt_serr_en_i = 1'b0;
        arm(8'h20, a);
        push(a + LONG_T, 8'h20, 1'b0, "R3");
        drain();
        check("R6 status without enables", {31'd0, dt_status_o}, 32'd1);
        clear_status();
        cfg_sec_short_i  = 1'b1;
        cfg_dt_serr_en_i = 1'b1;

        // R5 simultaneous expiry on two queues, single serr (R7)
        arm(8'h48, a);
        push(a + SHORT_T, 8'h48, 1'b1, "R5");
        drain();
        clear_status();

        // R8 frozen timers resume from held count
        cfg_dt_disable_i = 1'b1;
        arm(8'h04, a);
        repeat (3000) @(negedge clk);
        check("R8 frozen no status", {31'd0, dt_status_o}, 32'd0);
        cfg_dt_disable_i = 1'b0;
        push(cyc + SHORT_T, 8'h04, 1'b1, "R8");
        drain();
        clear_status();

        // R6 set wins over a clear on the same edge
        arm(8'h80, a);
        push(a + SHORT_T, 8'h80, 1'b1, "R6");
        while (cyc != a + SHORT_T - 1) @(negedge clk);
        sts_clr_i = 1'b1;
        @(negedge clk);
        sts_clr_i = 1'b0;
        check("R6 set beats clear", {31'd0, dt_status_o}, 32'd1);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule